// File: doc/BRIEF.md
# Clock Output Routing and Status Selector

This block decides what reaches each clock and status pin of a clock generator. It takes two internal clocks: a phase-adjusted (delayed) clock and a fixed-phase (non-delayed) clock. It also takes the PLL and phase-adjuster lock flags, the conditioned sync input, the regenerated sync and the divided oscillator. From these it forms the level driven on every output pin. The clock levels arrive as oversampled waveforms in the system clock domain. A rising edge of the delayed clock is detected by comparing its present sample with the sample from the previous cycle.

The main clock pair carries one of two sources: the non-delayed clock at full speed, or a half-rate clock that toggles on each delayed rising edge and so stays phase-aligned with the delayed channel. The differential delayed output carries the delayed clock unchanged. The single-ended delayed output passes through a power-of-two divider, and a new ratio takes effect only where a divided period ends. A single status pin shows one of four things, chosen by two enable bits and an input-select bit: nothing, phase-adjuster lock, PLL lock, or a reference. The function pin carries one of the two sync signals. Each of the five driven pins has a data bit and its own output enable, which models the high-impedance state.

A configuration word is captured on a load strobe and held in between.

Top module: `clk_out_router`

## Requirements
- R1: After synchronous reset the held configuration is: all five output enables 1, PLL status enabled, phase-adjuster status disabled, input select 1, half-rate source, divider code 0 and function select 0. As a result the status pin shows `pll_lock_i` and the main clock pins start at 0.
- R2: With source select 1, `clk_diff_o` and `clk_se_o` follow `nd_clk_i` in the same cycle.
- R3: With source select 0, the main clock pins carry a half-rate clock. It is 0 after reset, and it inverts in the cycle after a cycle in which `dly_clk_i` is sampled 1 following a 0. It holds at every other time.
- R4: Divider codes 0, 1, 2 and 3 on `dclk_se_o` give divide-by 1, 2, 4 and 8 of the delayed clock. With code 0 the output follows `dly_clk_i` directly. With code k>0 the output is 0 for the first 2^(k-1) delayed rising edges after the ratio takes effect (that edge counted as the first), then 1 for the next 2^(k-1), and so on. `dclk_diff_o` always carries the undivided `dly_clk_i`.
- R5: A changed divider code takes effect only on the delayed rising edge that completes the current divided period. The divided count restarts from that edge.
- R6: Status enable coding (PLL, phase-adjuster): 00 drives the status pin 0, 01 shows `dpa_lock_i`, and 10 shows `pll_lock_i`.
- R7: With both status enables set, input select 0 shows `sync_in_i` XOR the reference-polarity bit. Input select 1 shows `osc_div_i`.
- R8: Function select 0 routes `regen_sync_i` to `func_o`, and 1 routes `sync_in_i`.
- R9: Enable bit positions in `cfg_oe_i`: 0 is the delayed differential pin, 1 the delayed single-ended pin, 2 the main differential pin, 3 the main single-ended pin and 4 the function pin. A 0 in a bit drives that pin's enable output 0 and forces its data to 0. The other pins are not affected.
- R10: The configuration inputs take effect only at a clock edge where `cfg_load_i` is 1. At all other edges they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Capture configuration inputs |
| cfg_src_full_i | input | 1 | Main clock source: 1 full-speed non-delayed, 0 half-rate delayed |
| cfg_scale_i | input | 2 | Divider code for single-ended delayed output |
| cfg_en_pll_i | input | 1 | Status enable for PLL lock |
| cfg_en_dpa_i | input | 1 | Status enable for phase-adjuster lock |
| cfg_in_sel_i | input | 1 | Reference select when both status enables are set |
| cfg_ref_pol_i | input | 1 | Reference polarity applied to sync input |
| cfg_func_sel_i | input | 1 | Function pin source select |
| cfg_oe_i | input | 5 | Output enables, bit order as in R9 |
| dly_clk_i | input | 1 | Delayed clock level |
| nd_clk_i | input | 1 | Non-delayed clock level |
| pll_lock_i | input | 1 | PLL lock flag |
| dpa_lock_i | input | 1 | Phase-adjuster lock flag |
| sync_in_i | input | 1 | Conditioned sync input |
| osc_div_i | input | 1 | Divided oscillator |
| regen_sync_i | input | 1 | Regenerated sync |
| clk_diff_o | output | 1 | Main differential clock data |
| clk_diff_oe_o | output | 1 | Main differential enable |
| clk_se_o | output | 1 | Main single-ended clock data |
| clk_se_oe_o | output | 1 | Main single-ended enable |
| dclk_diff_o | output | 1 | Delayed differential clock data |
| dclk_diff_oe_o | output | 1 | Delayed differential enable |
| dclk_se_o | output | 1 | Divided delayed single-ended clock data |
| dclk_se_oe_o | output | 1 | Delayed single-ended enable |
| func_o | output | 1 | Function pin data |
| func_oe_o | output | 1 | Function pin enable |
| lockref_o | output | 1 | Status/reference pin |

## Verification
Two things can fall on the same delayed rising edge: a divider code change, and the end of a divided period (with the half-rate toggle on that same edge). The bench writes a new code while the divide-by-4 count sits partway through its period. It then issues further rising edges and checks that the old ratio survives the next two edges. On the edge that closes the period, the new ratio must start from a count of zero. The expected sequence is worked out from the edge count alone.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;

    localparam int SCALE_W = 2;
    localparam int N_OE    = 5;

    localparam int OE_DLY_DIFF = 0;
    localparam int OE_DLY_SE   = 1;
    localparam int OE_CLK_DIFF = 2;
    localparam int OE_CLK_SE   = 3;
    localparam int OE_FUNC     = 4;

    typedef struct packed {
        logic               src_full;
        logic [SCALE_W-1:0] scale;
        logic               en_pll;
        logic               en_dpa;
        logic               in_sel;
        logic               ref_pol;
        logic               func_sel;
        logic [N_OE-1:0]    oe;
    } route_cfg_t;

    localparam route_cfg_t CFG_RESET = '{
        src_full: 1'b0,
        scale:    '0,
        en_pll:   1'b1,
        en_dpa:   1'b0,
        in_sel:   1'b1,
        ref_pol:  1'b0,
        func_sel: 1'b0,
        oe:       '1
    };

    typedef enum logic [1:0] {
        LR_OFF = 2'd0,
        LR_DPA = 2'd1,
        LR_PLL = 2'd2,
        LR_REF = 2'd3
    } lr_mode_t;

    function automatic lr_mode_t lr_mode(input logic en_pll, input logic en_dpa);
        lr_mode_t m;
        case ({en_pll, en_dpa})
            2'b01:   m = LR_DPA;
            2'b10:   m = LR_PLL;
            2'b11:   m = LR_REF;
            default: m = LR_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dly_edge_track.sv
module dly_edge_track (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o,
    output logic half_o
);
    logic lvl_q;
    logic half_q;

    // previous sample follows the input even in reset, so edges stay coherent
    always_ff @(posedge clk) begin
        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
        end else if (rise_o) begin
            half_q <= ~half_q;
        end
    end

    assign half_o = half_q;
endmodule

// File: rtl/clk_pow2_scaler.sv
module clk_pow2_scaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             lvl_i,
    input  logic [SEL_W-1:0] req_i,
    output logic             out_o,
    output logic [SEL_W-1:0] act_o
);
    localparam int TAPS  = 1 << SEL_W;
    localparam int CNT_W = TAPS - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic [SEL_W-1:0] act_q;
    logic [TAPS-1:0]  taps;
    logic             period_end;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(act_q));
        end
    end

    assign period_end = ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (rise_i) begin
            if (period_end && (req_i != act_q)) begin
                act_q <= req_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign taps[0] = lvl_i;
    for (genvar g = 1; g < TAPS; g++) begin : g_tap
        assign taps[g] = cnt_q[g-1];
    end

    assign out_o = taps[act_q];
    assign act_o = act_q;
endmodule

// File: rtl/lockref_mux.sv
module lockref_mux
    import clk_route_pkg::*;
(
    input  logic en_pll_i,
    input  logic en_dpa_i,
    input  logic in_sel_i,
    input  logic ref_pol_i,
    input  logic pll_lock_i,
    input  logic dpa_lock_i,
    input  logic sync_in_i,
    input  logic osc_div_i,
    output logic out_o
);
    lr_mode_t mode;

    always_comb begin
        mode = lr_mode(en_pll_i, en_dpa_i);
        case (mode)
            LR_DPA:  out_o = dpa_lock_i;
            LR_PLL:  out_o = pll_lock_i;
            LR_REF:  out_o = in_sel_i ? osc_div_i : (sync_in_i ^ ref_pol_i);
            default: out_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/clk_out_router.sv
module clk_out_router
    import clk_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load_i,
    input  logic               cfg_src_full_i,
    input  logic [SCALE_W-1:0] cfg_scale_i,
    input  logic               cfg_en_pll_i,
    input  logic               cfg_en_dpa_i,
    input  logic               cfg_in_sel_i,
    input  logic               cfg_ref_pol_i,
    input  logic               cfg_func_sel_i,
    input  logic [N_OE-1:0]    cfg_oe_i,
    input  logic               dly_clk_i,
    input  logic               nd_clk_i,
    input  logic               pll_lock_i,
    input  logic               dpa_lock_i,
    input  logic               sync_in_i,
    input  logic               osc_div_i,
    input  logic               regen_sync_i,
    output logic               clk_diff_o,
    output logic               clk_diff_oe_o,
    output logic               clk_se_o,
    output logic               clk_se_oe_o,
    output logic               dclk_diff_o,
    output logic               dclk_diff_oe_o,
    output logic               dclk_se_o,
    output logic               dclk_se_oe_o,
    output logic               func_o,
    output logic               func_oe_o,
    output logic               lockref_o
);
    route_cfg_t         cfg_q;
    route_cfg_t         cfg_d;
    logic               rise_w;
    logic               half_w;
    logic               dclk_div_w;
    logic [SCALE_W-1:0] act_scale_w;
    logic               main_clk_w;
    logic               func_raw_w;
    logic [N_OE-1:0]    raw_w;
    logic [N_OE-1:0]    pin_w;

    always_comb begin
        cfg_d.src_full = cfg_src_full_i;
        cfg_d.scale    = cfg_scale_i;
        cfg_d.en_pll   = cfg_en_pll_i;
        cfg_d.en_dpa   = cfg_en_dpa_i;
        cfg_d.in_sel   = cfg_in_sel_i;
        cfg_d.ref_pol  = cfg_ref_pol_i;
        cfg_d.func_sel = cfg_func_sel_i;
        cfg_d.oe       = cfg_oe_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_load_i) begin
            cfg_q <= cfg_d;
        end
    end

    dly_edge_track edge_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (dly_clk_i),
        .rise_o (rise_w),
        .half_o (half_w)
    );

    clk_pow2_scaler #(.SEL_W(SCALE_W)) scaler_i (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise_w),
        .lvl_i  (dly_clk_i),
        .req_i  (cfg_q.scale),
        .out_o  (dclk_div_w),
        .act_o  (act_scale_w)
    );

    lockref_mux lockref_i (
        .en_pll_i   (cfg_q.en_pll),
        .en_dpa_i   (cfg_q.en_dpa),
        .in_sel_i   (cfg_q.in_sel),
        .ref_pol_i  (cfg_q.ref_pol),
        .pll_lock_i (pll_lock_i),
        .dpa_lock_i (dpa_lock_i),
        .sync_in_i  (sync_in_i),
        .osc_div_i  (osc_div_i),
        .out_o      (lockref_o)
    );

    assign main_clk_w = cfg_q.src_full ? nd_clk_i : half_w;
    assign func_raw_w = cfg_q.func_sel ? sync_in_i : regen_sync_i;

    assign raw_w[OE_DLY_DIFF] = dly_clk_i;
    assign raw_w[OE_DLY_SE]   = dclk_div_w;
    assign raw_w[OE_CLK_DIFF] = main_clk_w;
    assign raw_w[OE_CLK_SE]   = main_clk_w;
    assign raw_w[OE_FUNC]     = func_raw_w;

    for (genvar p = 0; p < N_OE; p++) begin : g_pin
        assign pin_w[p] = raw_w[p] & cfg_q.oe[p];
    end

    assign dclk_diff_o    = pin_w[OE_DLY_DIFF];
    assign dclk_se_o      = pin_w[OE_DLY_SE];
    assign clk_diff_o     = pin_w[OE_CLK_DIFF];
    assign clk_se_o       = pin_w[OE_CLK_SE];
    assign func_o         = pin_w[OE_FUNC];

    assign dclk_diff_oe_o = cfg_q.oe[OE_DLY_DIFF];
    assign dclk_se_oe_o   = cfg_q.oe[OE_DLY_SE];
    assign clk_diff_oe_o  = cfg_q.oe[OE_CLK_DIFF];
    assign clk_se_oe_o    = cfg_q.oe[OE_CLK_SE];
    assign func_oe_o      = cfg_q.oe[OE_FUNC];
endmodule

// File: rtl/clk_out_router_chk.sv
module clk_out_router_chk
    import clk_route_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_load_i,
    input logic [N_OE-1:0]    cfg_oe_i,
    input logic               dly_clk_i,
    input logic               nd_clk_i,
    input logic               clk_diff_o,
    input logic               clk_diff_oe_o,
    input logic               clk_se_oe_o,
    input logic               dclk_diff_o,
    input logic               dclk_diff_oe_o,
    input logic               lockref_o,
    input route_cfg_t         cfg_q,
    input logic               half_q,
    input logic [SCALE_W-1:0] act_scale
);
    // R2: full-speed source reaches the enabled differential pin
    a_r2_full_follow: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src_full && clk_diff_oe_o) |-> (clk_diff_o == nd_clk_i));

    // R3: half-rate clock flips after each delayed rising edge
    a_r3_half_toggle: assert property (@(posedge clk) disable iff (rst)
        $rose(dly_clk_i) |=> (half_q != $past(half_q)));

    // R3: half-rate clock holds without a delayed rising edge
    a_r3_half_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(dly_clk_i) |=> $stable(half_q));

    // R4: delayed differential pin is never divided
    a_r4_diff_undivided: assert property (@(posedge clk) disable iff (rst)
        dclk_diff_oe_o |-> (dclk_diff_o == dly_clk_i));

    // R5: active ratio only moves right after a delayed rising edge
    a_r5_ratio_at_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_scale) |-> ($past(dly_clk_i) && !$past(dly_clk_i, 2)));

    // R6: both status enables clear drive the pin low
    a_r6_status_off: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en_pll && !cfg_q.en_dpa) |-> !lockref_o);

    // R10: enable on a load edge is visible in the next cycle
    a_r10_load_oe: assert property (@(posedge clk) disable iff (rst)
        cfg_load_i |=> (clk_se_oe_o == $past(cfg_oe_i[OE_CLK_SE])));

    // R10: without a load the enables hold
    a_r10_hold_oe: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_i |=> $stable(clk_se_oe_o));
endmodule

bind clk_out_router clk_out_router_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_load_i     (cfg_load_i),
    .cfg_oe_i       (cfg_oe_i),
    .dly_clk_i      (dly_clk_i),
    .nd_clk_i       (nd_clk_i),
    .clk_diff_o     (clk_diff_o),
    .clk_diff_oe_o  (clk_diff_oe_o),
    .clk_se_oe_o    (clk_se_oe_o),
    .dclk_diff_o    (dclk_diff_o),
    .dclk_diff_oe_o (dclk_diff_oe_o),
    .lockref_o      (lockref_o),
    .cfg_q          (cfg_q),
    .half_q         (half_w),
    .act_scale      (act_scale_w)
);

// File: tb/clk_out_router_tb_top.sv
module clk_out_router_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load_i = 1'b0;
    logic       cfg_src_full_i = 1'b0;
    logic [1:0] cfg_scale_i = 2'd0;
    logic       cfg_en_pll_i = 1'b1;
    logic       cfg_en_dpa_i = 1'b0;
    logic       cfg_in_sel_i = 1'b1;
    logic       cfg_ref_pol_i = 1'b0;
    logic       cfg_func_sel_i = 1'b0;
    logic [4:0] cfg_oe_i = 5'b11111;
    logic       dly_clk_i = 1'b0;
    logic       nd_clk_i = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic       dpa_lock_i = 1'b0;
    logic       sync_in_i = 1'b0;
    logic       osc_div_i = 1'b0;
    logic       regen_sync_i = 1'b0;
    logic       clk_diff_o, clk_diff_oe_o, clk_se_o, clk_se_oe_o;
    logic       dclk_diff_o, dclk_diff_oe_o, dclk_se_o, dclk_se_oe_o;
    logic       func_o, func_oe_o, lockref_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clk_out_router dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_load_i     (cfg_load_i),
        .cfg_src_full_i (cfg_src_full_i),
        .cfg_scale_i    (cfg_scale_i),
        .cfg_en_pll_i   (cfg_en_pll_i),
        .cfg_en_dpa_i   (cfg_en_dpa_i),
        .cfg_in_sel_i   (cfg_in_sel_i),
        .cfg_ref_pol_i  (cfg_ref_pol_i),
        .cfg_func_sel_i (cfg_func_sel_i),
        .cfg_oe_i       (cfg_oe_i),
        .dly_clk_i      (dly_clk_i),
        .nd_clk_i       (nd_clk_i),
        .pll_lock_i     (pll_lock_i),
        .dpa_lock_i     (dpa_lock_i),
        .sync_in_i      (sync_in_i),
        .osc_div_i      (osc_div_i),
        .regen_sync_i   (regen_sync_i),
        .clk_diff_o     (clk_diff_o),
        .clk_diff_oe_o  (clk_diff_oe_o),
        .clk_se_o       (clk_se_o),
        .clk_se_oe_o    (clk_se_oe_o),
        .dclk_diff_o    (dclk_diff_o),
        .dclk_diff_oe_o (dclk_diff_oe_o),
        .dclk_se_o      (dclk_se_o),
        .dclk_se_oe_o   (dclk_se_oe_o),
        .func_o         (func_o),
        .func_oe_o      (func_oe_o),
        .lockref_o      (lockref_o)
    );

    // {en_pll,en_dpa,in_sel,ref_pol,func_sel,pll,dpa,sync,osc,regen,exp_lock,exp_func}
    localparam logic [11:0] VEC [0:9] = '{
        12'b000001111101,
        12'b010010100110,
        12'b010001000000,
        12'b100011010011,
        12'b101000101101,
        12'b110010010011,
        12'b110101111000,
        12'b110100000010,
        12'b111100001111,
        12'b111011110001
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [4:0] got, input logic [4:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic load(input logic full, input logic [1:0] sc, input logic ep, input logic ed,
                        input logic is, input logic rp, input logic fs, input logic [4:0] oe);
        cfg_src_full_i = full; cfg_scale_i = sc; cfg_en_pll_i = ep; cfg_en_dpa_i = ed;
        cfg_in_sel_i = is; cfg_ref_pol_i = rp; cfg_func_sel_i = fs; cfg_oe_i = oe;
        cfg_load_i = 1'b1;
        step();
        cfg_load_i = 1'b0;
    endtask

    // one delayed rising edge, then sample the divided output, then drop the level
    task automatic rise_chk(input logic exp, input string tag);
        dly_clk_i = 1'b1;
        step();
        chk({4'b0, dclk_se_o}, {4'b0, exp}, tag);
        dly_clk_i = 1'b0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        pll_lock_i = 1'b1; dpa_lock_i = 1'b0;
        #1;
        chk({func_oe_o, clk_se_oe_o, clk_diff_oe_o, dclk_se_oe_o, dclk_diff_oe_o}, 5'b11111, "R1 enables");
        chk({4'b0, lockref_o}, 5'd1, "R1 status shows pll lock");
        chk({3'b0, clk_diff_o, clk_se_o}, 5'd0, "R1 half-rate starts low");

        // R3 half-rate toggling; R4 code 0 follows level
        dly_clk_i = 1'b1;
        step();
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00011, "R3 first edge toggles");
        chk({3'b0, dclk_se_o, dclk_diff_o}, 5'b00011, "R4 code0 and diff follow level");
        dly_clk_i = 1'b0;
        step();
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00011, "R3 hold without edge");
        chk({4'b0, dclk_se_o}, 5'd0, "R4 code0 low level");
        step();
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00011, "R3 hold idle cycle");
        dly_clk_i = 1'b1;
        step();
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00000, "R3 second edge toggles");
        dly_clk_i = 1'b0;
        step();

        // R2 full-speed source
        load(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11111);
        nd_clk_i = 1'b1; #1;
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00011, "R2 follows nd high");
        nd_clk_i = 1'b0; #1;
        chk({3'b0, clk_diff_o, clk_se_o}, 5'b00000, "R2 follows nd low");

        // R4 divide-by-2
        load(1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11111);
        rise_chk(1'b0, "R4 div2 e0");
        rise_chk(1'b1, "R4 div2 e1");
        rise_chk(1'b0, "R4 div2 e2");
        rise_chk(1'b1, "R4 div2 e3");
        // R4 divide-by-4
        load(1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11111);
        rise_chk(1'b0, "R4 div4 e0");
        rise_chk(1'b0, "R4 div4 e1");
        // R5 change requested mid-period: old ratio holds until period end
        load(1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11111);
        rise_chk(1'b1, "R5 old ratio e2");
        rise_chk(1'b1, "R5 old ratio e3");
        rise_chk(1'b0, "R5 new ratio starts");
        rise_chk(1'b0, "R4 div8 e1");
        rise_chk(1'b0, "R4 div8 e2");
        rise_chk(1'b0, "R4 div8 e3");
        rise_chk(1'b1, "R4 div8 e4");
        // R4 differential output stays undivided under code 3
        dly_clk_i = 1'b1; #1;
        chk({4'b0, dclk_diff_o}, 5'd1, "R4 diff undivided");
        dly_clk_i = 1'b0; #1;
        chk({4'b0, dclk_diff_o}, 5'd0, "R4 diff undivided low");
        step();

        // R6 R7 R8 vector table
        for (int i = 0; i < 10; i++) begin
            logic [11:0] v;
            v = VEC[i];
            load(1'b0, 2'd3, v[11], v[10], v[9], v[8], v[7], 5'b11111);
            pll_lock_i = v[6]; dpa_lock_i = v[5]; sync_in_i = v[4];
            osc_div_i = v[3]; regen_sync_i = v[2];
            #1;
            chk({4'b0, lockref_o}, {4'b0, v[1]}, (v[11] & v[10]) ? "R7 status ref" : "R6 status lock");
            chk({4'b0, func_o}, {4'b0, v[0]}, "R8 function pin");
        end

        // R9 enables gate data
        load(1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'b10110);
        nd_clk_i = 1'b1; sync_in_i = 1'b1; pll_lock_i = 1'b1; dly_clk_i = 1'b1;
        #1;
        chk({func_oe_o, clk_se_oe_o, clk_diff_oe_o, dclk_se_oe_o, dclk_diff_oe_o}, 5'b10110, "R9 enable outputs");
        chk({3'b0, dclk_diff_o, clk_se_o}, 5'd0, "R9 disabled pins forced low");
        chk({3'b0, clk_diff_o, func_o}, 5'b00011, "R9 enabled pins unaffected");
        step();
        dly_clk_i = 1'b0;

        // R10 config ignored without load
        cfg_oe_i = 5'b00000; cfg_src_full_i = 1'b0; cfg_en_pll_i = 1'b0; cfg_func_sel_i = 1'b0;
        regen_sync_i = 1'b0;
        step();
        step();
        chk({func_oe_o, clk_se_oe_o, clk_diff_oe_o, dclk_se_oe_o, dclk_diff_oe_o}, 5'b10110, "R10 enables held");
        chk({3'b0, lockref_o, clk_diff_o}, 5'b00011, "R10 status and source held");
        chk({4'b0, func_o}, 5'd1, "R10 function select held");
        cfg_load_i = 1'b1;
        step();
        cfg_load_i = 1'b0;
        chk({func_oe_o, clk_se_oe_o, clk_diff_oe_o, dclk_se_oe_o, dclk_diff_oe_o}, 5'b00000, "R10 load applies");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule